// File: doc/BRIEF.md
# Colour-Correction Matrix with YCoCg Conversion and Contrast Statistics

This block is a per-pixel colour stage in a camera pipeline. Each RGB pixel passes through a programmable signed 3×3 correction matrix. The rounded and saturated result feeds the reversible YCoCg lifting transform in the very next stage, with no buffer in between. The block emits luma, orange chroma and green chroma.

In the same pass, the block folds every luma sample into a running minimum and maximum for the current frame. At the end of the frame it latches that pair. During the blanking gap it derives a fixed-point stretch factor from the pair by serial division. Pixels of the following frames then receive a linearly stretched luma alongside the plain one.

Frames are delimited by start and end markers that travel with the pixels. The caller programs the coefficients, streams pixels, and leaves a short gap after each frame so that the new stretch settings can take effect.

Top module: `ccm_ycocg`

## Requirements
- R1: Coefficient slot k = 3·row + col occupies bits [12k+11:12k] of `coef`. It is 12-bit two's complement, and 256 represents 1.0. Row 0 produces corrected red, row 1 green and row 2 blue. Column 0 multiplies R, column 1 G and column 2 B. Each corrected channel is floor((Σ coef·in + 128) / 256).
- R2: Each corrected channel is saturated to the range 0..255 before conversion.
- R3: With corrected values Rc, Gc, Bc, the outputs are Co = Rc − Bc, Cg = Gc − (Bc + (Co >> 1)) and Y = Bc + (Co >> 1) + (Cg >> 1). The shifts are arithmetic (floor). Co and Cg are 9-bit two's complement.
- R4: Rc, Gc and Bc are exactly recoverable from (Y, Co, Cg), and each recovered value lies in 0..255.
- R5: `out_valid` and all pixel outputs appear on the third rising edge after the pixel is sampled. `out_valid` follows `in_valid` with that delay. Reset clears every output to zero.
- R6: `stat_ymin` and `stat_ymax` hold the minimum and maximum Y of the last completed frame. They change only on the edge where that frame's last pixel reaches the outputs. Reset sets both to 0.
- R7: Until the first frame has completed, `out_ys` equals `out_y`.
- R8: After a frame with max > min, later pixels receive out_ys = clamp(floor(((Y − min)·RS + 128) / 256), 0, 255), where RS = floor(255·256 / (max − min)). The new setting is in effect within 24 cycles of the frame's last pixel being sampled.
- R9: After a frame with max ≤ min (flat or single-pixel), `out_ys` equals `out_y` again.
- R10: `frame_start` and `frame_end` count only in a cycle with `in_valid` high. A frame's statistics include the pixel that carries `frame_start` and the pixel that carries `frame_end`, and no pixel of an earlier frame. Both markers may sit on one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| frame_start | input | 1 | Marks the first pixel of a frame |
| frame_end | input | 1 | Marks the last pixel of a frame |
| in_r | input | 8 | Red input |
| in_g | input | 8 | Green input |
| in_b | input | 8 | Blue input |
| coef | input | 108 | Nine signed 12-bit matrix coefficients |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Luma |
| out_co | output | 9 | Orange chroma, signed |
| out_cg | output | 9 | Green chroma, signed |
| out_ys | output | 8 | Contrast-stretched luma |
| stat_ymin | output | 8 | Luma minimum of the last completed frame |
| stat_ymax | output | 8 | Luma maximum of the last completed frame |

## Verification
The luma of the frame-end pixel is folded into the running statistics on the same edge that latches them. A frame's extreme value placed on its final pixel therefore shows whether that pixel was counted or dropped. The same holds on the start side, where the first pixel both clears and seeds the running pair. The bench places the darkest or brightest sample of several frames on those marker pixels, and ends one frame with a single pixel carrying both markers. Each latched minimum and maximum is compared against a model that folds the frame's own lumas. Marker pulses sent with `in_valid` low are also included, and must not end or restart a frame.

// File: rtl/ccy_pkg.sv
package ccy_pkg;

    localparam int PIX_W_DEF  = 8;
    localparam int COEF_W_DEF = 12;
    localparam int FRAC_DEF   = 8;

    // Flags that travel beside a pixel through every stage
    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
    } pix_tag_t;

    typedef enum logic [1:0] {
        DIV_IDLE,
        DIV_RUN,
        DIV_DONE
    } div_state_e;

endpackage

// File: rtl/ccy_matrix.sv
module ccy_matrix
    import ccy_pkg::*;
#(
    parameter int PW   = PIX_W_DEF,
    parameter int CW   = COEF_W_DEF,
    parameter int FRAC = FRAC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  pix_tag_t          in_tag,
    input  logic [PW-1:0]     in_r,
    input  logic [PW-1:0]     in_g,
    input  logic [PW-1:0]     in_b,
    input  logic [9*CW-1:0]   coef,
    output pix_tag_t          out_tag,
    output logic [PW-1:0]     out_r,
    output logic [PW-1:0]     out_g,
    output logic [PW-1:0]     out_b
);

    localparam int AW   = PW + CW + 3;
    localparam int BMAX = (1 << PW) - 1;
    localparam logic signed [AW-1:0] HALF = AW'(1 << (FRAC - 1));
    localparam logic signed [AW-1:0] SMAX = AW'(BMAX);

    logic [PW-1:0] pix_in [3];
    logic [PW-1:0] cc_sat [3];

    assign pix_in[0] = in_r;
    assign pix_in[1] = in_g;
    assign pix_in[2] = in_b;

    for (genvar row = 0; row < 3; row++) begin : g_row
        logic signed [AW-1:0] prod [3];
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] scaled;

        for (genvar col = 0; col < 3; col++) begin : g_col
            logic signed [CW-1:0] cs;
            logic signed [PW:0]   xs;
            assign cs        = $signed(coef[(row*3+col)*CW +: CW]);
            assign xs        = $signed({1'b0, pix_in[col]});
            assign prod[col] = AW'(xs) * AW'(cs);
        end

        assign acc    = prod[0] + prod[1] + prod[2] + HALF;
        assign scaled = acc >>> FRAC;
        assign cc_sat[row] = scaled[AW-1]   ? '0 :
                             (scaled > SMAX) ? PW'(BMAX) :
                                               scaled[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_tag <= '0;
            out_r   <= '0;
            out_g   <= '0;
            out_b   <= '0;
        end else begin
            out_tag <= in_tag;
            out_r   <= cc_sat[0];
            out_g   <= cc_sat[1];
            out_b   <= cc_sat[2];
        end
    end

endmodule

// File: rtl/ccy_lift.sv
module ccy_lift
    import ccy_pkg::*;
#(
    parameter int PW = PIX_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  pix_tag_t           in_tag,
    input  logic [PW-1:0]      in_r,
    input  logic [PW-1:0]      in_g,
    input  logic [PW-1:0]      in_b,
    output pix_tag_t           out_tag,
    output logic [PW-1:0]      out_y,
    output logic signed [PW:0] out_co,
    output logic signed [PW:0] out_cg
);

    logic signed [PW:0] r9, g9, b9;
    logic signed [PW:0] co, t, cg, y9;
    logic               unused_ytop;

    assign r9 = $signed({1'b0, in_r});
    assign g9 = $signed({1'b0, in_g});
    assign b9 = $signed({1'b0, in_b});

    // Lifting steps: every step is an add of a shifted earlier term
    assign co = r9 - b9;
    assign t  = b9 + (co >>> 1);
    assign cg = g9 - t;
    assign y9 = t + (cg >>> 1);

    assign unused_ytop = y9[PW];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_tag <= '0;
            out_y   <= '0;
            out_co  <= '0;
            out_cg  <= '0;
        end else begin
            out_tag <= in_tag;
            out_y   <= y9[PW-1:0];
            out_co  <= co;
            out_cg  <= cg;
        end
    end

endmodule

// File: rtl/ccy_recip.sv
module ccy_recip
    import ccy_pkg::*;
#(
    parameter int PW = PIX_W_DEF,
    parameter int RF = FRAC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PW-1:0]    den,
    output logic             done,
    output logic [PW+RF-1:0] quot
);

    localparam int QW   = PW + RF;
    localparam int CNTW = $clog2(QW + 1);
    localparam int BMAX = (1 << PW) - 1;
    localparam logic [QW-1:0] NUM = QW'(BMAX) << RF;

    div_state_e      state;
    logic [PW-1:0]   rem;
    logic [PW-1:0]   den_q;
    logic [QW-1:0]   num_sh;
    logic [CNTW-1:0] cnt;
    logic [PW:0]     rem_sh;
    logic            fits;

    assign rem_sh = {rem, num_sh[QW-1]};
    assign fits   = rem_sh >= {1'b0, den_q};
    assign done   = (state == DIV_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= DIV_IDLE;
            rem    <= '0;
            den_q  <= '0;
            num_sh <= '0;
            cnt    <= '0;
            quot   <= '0;
        end else if (start) begin
            state  <= DIV_RUN;
            rem    <= '0;
            den_q  <= den;
            num_sh <= NUM;
            cnt    <= CNTW'(QW);
            quot   <= '0;
        end else begin
            case (state)
                DIV_RUN: begin
                    rem    <= fits ? PW'(rem_sh - {1'b0, den_q}) : rem_sh[PW-1:0];
                    quot   <= {quot[QW-2:0], fits};
                    num_sh <= num_sh << 1;
                    cnt    <= cnt - 1'b1;
                    if (cnt == CNTW'(1))
                        state <= DIV_DONE;
                end
                DIV_DONE: state <= DIV_IDLE;
                default:  state <= DIV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ccy_stats.sv
module ccy_stats
    import ccy_pkg::*;
#(
    parameter int PW = PIX_W_DEF,
    parameter int RF = FRAC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  pix_tag_t         in_tag,
    input  logic [PW-1:0]    in_y,
    output logic [PW-1:0]    stat_min,
    output logic [PW-1:0]    stat_max,
    output logic [PW-1:0]    act_min,
    output logic [PW+RF-1:0] act_rs
);

    localparam int QW   = PW + RF;
    localparam int BMAX = (1 << PW) - 1;
    localparam logic [QW-1:0] RS_ONE = QW'(1) << RF;

    logic [PW-1:0] run_min, run_max;
    logic [PW-1:0] base_min, base_max;
    logic [PW-1:0] upd_min, upd_max;
    logic [PW-1:0] range_w;
    logic [PW-1:0] pend_min;
    logic          go;
    logic          div_done;
    logic [QW-1:0] div_q;

    // A starting pixel clears the running pair before being folded in
    assign base_min = in_tag.sof ? PW'(BMAX) : run_min;
    assign base_max = in_tag.sof ? '0        : run_max;
    assign upd_min  = (in_tag.vld && in_y < base_min) ? in_y : base_min;
    assign upd_max  = (in_tag.vld && in_y > base_max) ? in_y : base_max;
    assign range_w  = (stat_max > stat_min) ? stat_max - stat_min : '0;

    ccy_recip #(.PW(PW), .RF(RF)) i_recip (
        .clk   (clk),
        .rst   (rst),
        .start (go && range_w != '0),
        .den   (range_w),
        .done  (div_done),
        .quot  (div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_min  <= PW'(BMAX);
            run_max  <= '0;
            stat_min <= '0;
            stat_max <= '0;
            go       <= 1'b0;
            pend_min <= '0;
            act_min  <= '0;
            act_rs   <= RS_ONE;
        end else begin
            run_min <= upd_min;
            run_max <= upd_max;
            go      <= in_tag.eof;
            if (in_tag.eof) begin
                stat_min <= upd_min;
                stat_max <= upd_max;
            end
            if (go) begin
                pend_min <= stat_min;
                if (range_w == '0) begin
                    act_min <= '0;
                    act_rs  <= RS_ONE;
                end
            end
            if (div_done) begin
                act_min <= pend_min;
                act_rs  <= div_q;
            end
        end
    end

endmodule

// File: rtl/ccy_stretch.sv
module ccy_stretch
    import ccy_pkg::*;
#(
    parameter int PW = PIX_W_DEF,
    parameter int RF = FRAC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [PW-1:0]      in_y,
    input  logic signed [PW:0] in_co,
    input  logic signed [PW:0] in_cg,
    input  logic [PW-1:0]      act_min,
    input  logic [PW+RF-1:0]   act_rs,
    output logic               out_valid,
    output logic [PW-1:0]      out_y,
    output logic signed [PW:0] out_co,
    output logic signed [PW:0] out_cg,
    output logic [PW-1:0]      out_ys
);

    localparam int QW   = PW + RF;
    localparam int MW   = PW + QW + 3;
    localparam int BMAX = (1 << PW) - 1;
    localparam logic signed [MW-1:0] HALF = MW'(1 << (RF - 1));
    localparam logic signed [MW-1:0] SMAX = MW'(BMAX);

    logic signed [PW+1:0] diff;
    logic signed [MW-1:0] prod, scaled;
    logic [PW-1:0]        ys_c;

    assign diff   = $signed({2'b00, in_y}) - $signed({2'b00, act_min});
    assign prod   = MW'(diff) * MW'($signed({1'b0, act_rs})) + HALF;
    assign scaled = prod >>> RF;
    assign ys_c   = scaled[MW-1]   ? '0 :
                    (scaled > SMAX) ? PW'(BMAX) :
                                      scaled[PW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y     <= '0;
            out_co    <= '0;
            out_cg    <= '0;
            out_ys    <= '0;
        end else begin
            out_valid <= in_vld;
            out_y     <= in_y;
            out_co    <= in_co;
            out_cg    <= in_cg;
            out_ys    <= ys_c;
        end
    end

endmodule

// File: rtl/ccm_ycocg.sv
module ccm_ycocg
    import ccy_pkg::*;
#(
    parameter int PW   = PIX_W_DEF,
    parameter int CW   = COEF_W_DEF,
    parameter int FRAC = FRAC_DEF,
    parameter int RF   = FRAC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic [PW-1:0]      in_r,
    input  logic [PW-1:0]      in_g,
    input  logic [PW-1:0]      in_b,
    input  logic [9*CW-1:0]    coef,
    output logic               out_valid,
    output logic [PW-1:0]      out_y,
    output logic signed [PW:0] out_co,
    output logic signed [PW:0] out_cg,
    output logic [PW-1:0]      out_ys,
    output logic [PW-1:0]      stat_ymin,
    output logic [PW-1:0]      stat_ymax
);

    pix_tag_t           tag0, tag1, tag2;
    logic [PW-1:0]      rc, gc, bc;
    logic [PW-1:0]      y2;
    logic signed [PW:0] co2, cg2;
    logic [PW-1:0]      act_min;
    logic [PW+RF-1:0]   act_rs;

    assign tag0.vld = in_valid;
    assign tag0.sof = in_valid & frame_start;
    assign tag0.eof = in_valid & frame_end;

    ccy_matrix #(.PW(PW), .CW(CW), .FRAC(FRAC)) i_matrix (
        .clk     (clk),
        .rst     (rst),
        .in_tag  (tag0),
        .in_r    (in_r),
        .in_g    (in_g),
        .in_b    (in_b),
        .coef    (coef),
        .out_tag (tag1),
        .out_r   (rc),
        .out_g   (gc),
        .out_b   (bc)
    );

    ccy_lift #(.PW(PW)) i_lift (
        .clk     (clk),
        .rst     (rst),
        .in_tag  (tag1),
        .in_r    (rc),
        .in_g    (gc),
        .in_b    (bc),
        .out_tag (tag2),
        .out_y   (y2),
        .out_co  (co2),
        .out_cg  (cg2)
    );

    ccy_stats #(.PW(PW), .RF(RF)) i_stats (
        .clk      (clk),
        .rst      (rst),
        .in_tag   (tag2),
        .in_y     (y2),
        .stat_min (stat_ymin),
        .stat_max (stat_ymax),
        .act_min  (act_min),
        .act_rs   (act_rs)
    );

    ccy_stretch #(.PW(PW), .RF(RF)) i_stretch (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (tag2.vld),
        .in_y      (y2),
        .in_co     (co2),
        .in_cg     (cg2),
        .act_min   (act_min),
        .act_rs    (act_rs),
        .out_valid (out_valid),
        .out_y     (out_y),
        .out_co    (out_co),
        .out_cg    (out_cg),
        .out_ys    (out_ys)
    );

endmodule

// File: rtl/ccm_ycocg_chk.sv
module ccm_ycocg_chk #(
    parameter int PW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               frame_end,
    input logic               out_valid,
    input logic [PW-1:0]      out_y,
    input logic signed [PW:0] out_co,
    input logic signed [PW:0] out_cg,
    input logic [PW-1:0]      out_ys,
    input logic [PW-1:0]      stat_ymin,
    input logic [PW-1:0]      stat_ymax
);

    localparam int XW = PW + 3;
    localparam logic signed [XW-1:0] TOP = XW'((1 << PW) - 1);

    logic signed [XW-1:0] yx, cox, cgx, tx, bx, gx, rx;
    logic                 ended;

    assign yx  = $signed({3'b000, out_y});
    assign cox = XW'(out_co);
    assign cgx = XW'(out_cg);
    assign tx  = yx - (cgx >>> 1);
    assign gx  = cgx + tx;
    assign bx  = tx - (cox >>> 1);
    assign rx  = bx + cox;

    always_ff @(posedge clk) begin
        if (rst)
            ended <= 1'b0;
        else if (in_valid && frame_end)
            ended <= 1'b1;
    end

    // R5: valid output three edges after valid input
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, 3));

    // R4: inverse lifting gives channels inside the pixel range
    assert_lossless_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rx >= 0 && rx <= TOP && gx >= 0 && gx <= TOP &&
                       bx >= 0 && bx <= TOP));

    // R6: statistics move only when a frame end reaches the outputs
    assert_stats_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(stat_ymin) || !$stable(stat_ymax)) |-> $past(in_valid && frame_end, 3));

    // R7: no stretch before any frame has ended
    assert_identity_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ended) |-> out_ys == out_y);

endmodule

bind ccm_ycocg ccm_ycocg_chk #(.PW(PW)) i_chk (.*);

// File: tb/test_ccm_ycocg.sv
`timescale 1ns/1ps
module test_ccm_ycocg;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               frame_start = 1'b0;
    logic               frame_end = 1'b0;
    logic [7:0]         in_r = '0, in_g = '0, in_b = '0;
    logic [107:0]       coef = '0;
    logic               out_valid;
    logic [7:0]         out_y, out_ys, stat_ymin, stat_ymax;
    logic signed [8:0]  out_co, out_cg;

    ccm_ycocg i_ccm_ycocg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
        .frame_end(frame_end), .in_r(in_r), .in_g(in_g), .in_b(in_b), .coef(coef),
        .out_valid(out_valid), .out_y(out_y), .out_co(out_co), .out_cg(out_cg),
        .out_ys(out_ys), .stat_ymin(stat_ymin), .stat_ymax(stat_ymax)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    y;
        int    co;
        int    cg;
        int    ys;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    nchk = 0, nfail = 0;
    int    cf[9];
    int    cur_min = 0, cur_rs = 256;
    string mode = "R7";
    int    fmin = 255, fmax = 0, lat_min = 0, lat_max = 0;
    bit    finished = 1'b0;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v < 0) ? 0 : (v > 255) ? 255 : v;
    endfunction

    task automatic load_coef(int a[9]);
        for (int k = 0; k < 9; k++) begin
            cf[k] = a[k];
            coef[k*12 +: 12] = a[k][11:0];
        end
    endtask

    // R1, R2, R3 model of the conversion, R7/R8/R9 model of the stretch
    task automatic send_pix(int r, int g, int b, bit sof, bit eof);
        int   c[3];
        int   co, t, cg, y, ys;
        exp_t e;
        @(posedge clk); #1;
        in_valid = 1'b1; in_r = r[7:0]; in_g = g[7:0]; in_b = b[7:0];
        frame_start = sof; frame_end = eof;
        for (int row = 0; row < 3; row++)
            c[row] = sat((cf[row*3]*r + cf[row*3+1]*g + cf[row*3+2]*b + 128) >>> 8);
        co = c[0] - c[2];
        t  = c[2] + (co >>> 1);
        cg = c[1] - t;
        y  = t + (cg >>> 1);
        ys = sat(((y - cur_min) * cur_rs + 128) >>> 8);
        e.y = y; e.co = co; e.cg = cg; e.ys = ys; e.tag = mode;
        sb.push_back(e);
        if (sof) begin fmin = 255; fmax = 0; end
        if (y < fmin) fmin = y;
        if (y > fmax) fmax = y;
        if (eof) begin lat_min = fmin; lat_max = fmax; end
    endtask

    // R10: markers and data while in_valid is low must be ignored
    task automatic idle(int n, bit junk);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_r = 8'hA5; in_g = 8'h3C; in_b = 8'hF0;
            frame_start = junk; frame_end = junk;
        end
        frame_start = 1'b0; frame_end = 1'b0;
    endtask

    task automatic settle(string req);
        idle(40, 1'b0);
        @(negedge clk);
        chk({req, " stat_ymin"}, int'(stat_ymin), lat_min);
        chk({req, " stat_ymax"}, int'(stat_ymax), lat_max);
        if (lat_max > lat_min) begin
            cur_rs = (255 * 256) / (lat_max - lat_min);
            cur_min = lat_min;
            mode = "R8";
        end else begin
            cur_rs = 256;
            cur_min = 0;
            mode = "R9";
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                chk("R5 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R3 Y",  int'(out_y), e.y);
                chk("R3 Co", int'(out_co), e.co);
                chk("R3 Cg", int'(out_cg), e.cg);
                chk({e.tag, " stretched Y"}, int'(out_ys), e.ys);
            end
        end
    end

    initial begin
        int ident[9] = '{256, 0, 0, 0, 256, 0, 0, 0, 256};
        int mix[9]   = '{300, -40, 0, -20, 280, -10, 0, -60, 330};
        load_coef(ident);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R5 reset out_valid", int'(out_valid), 0);
        chk("R5 reset out_y", int'(out_y), 0);
        chk("R6 reset stat_ymin", int'(stat_ymin), 0);
        chk("R6 reset stat_ymax", int'(stat_ymax), 0);
        @(posedge clk); #1 rst = 1'b0;

        // Frame A: identity matrix, stretch still identity (R7), gaps with junk markers (R10)
        send_pix(10, 20, 30, 1, 0);
        send_pix(200, 100, 50, 0, 0);
        idle(2, 1'b1);
        send_pix(90, 180, 45, 0, 0);
        send_pix(30, 200, 220, 0, 0);
        idle(1, 1'b1);
        send_pix(60, 40, 20, 0, 1);
        settle("R6");

        // Frame B: signed gains with saturation (R1, R2), stretched by A (R8)
        load_coef(mix);
        send_pix(250, 10, 250, 1, 0);
        send_pix(0, 255, 0, 0, 0);
        send_pix(255, 255, 255, 0, 0);
        send_pix(128, 64, 32, 0, 0);
        send_pix(5, 5, 5, 0, 0);
        send_pix(40, 220, 100, 0, 0);
        send_pix(255, 0, 255, 0, 0);
        send_pix(180, 90, 200, 0, 1);
        settle("R6");

        // Frame C: flat frame, stretched by B
        load_coef(ident);
        for (int i = 0; i < 4; i++)
            send_pix(100, 100, 100, i == 0, i == 3);
        settle("R6");

        // Frame D: identity stretch after flat frame (R9); fresh stats (R10)
        send_pix(0, 0, 0, 1, 0);
        send_pix(20, 120, 220, 0, 0);
        send_pix(255, 255, 255, 0, 0);
        send_pix(70, 30, 10, 0, 1);
        settle("R10");

        // Frame E: single pixel carrying both markers (R10), stretched by D
        send_pix(150, 60, 90, 1, 1);
        settle("R10");

        // Frame F: identity again after the single-pixel frame (R9)
        send_pix(12, 240, 99, 1, 0);
        send_pix(230, 15, 77, 0, 0);
        send_pix(64, 64, 200, 0, 1);
        settle("R6");

        idle(5, 1'b0);
        chk("R5 scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule